// File: doc/BRIEF.md
# Gated Sticky Interrupt Status Unit

This block turns single-cycle event pulses from a transfer engine into sticky status bits and folds them into one level interrupt request. Each event has a fixed bit position. Two separate mask registers act on every bit. The capture-enable register decides whether a pulse is recorded at all. The request-gate register decides whether a recorded and enabled bit may drive the request line.

Software reads the status word and clears handled bits by writing ones to them. It can also quiet a source by dropping its enable bit. The status bits never clear by themselves, so a source stays visible until software clears it. A soft-reset pulse from the engine is itself reported as an event, because it leaves both data FIFOs empty.

Top module: `irq_status_unit`

## Requirements
- R1: While `rst` is high on a clock edge, all status, capture-enable and request-gate bits become 0, and `irq` is low after that edge.
- R2: A status bit is set at a clock edge only when its event input is high at that edge and its capture-enable bit was already set before that edge. The bit positions are: TX empty 0, TX full 1, TX threshold 2, RX empty 3, RX full 4, RX threshold 5, descriptor done 9, packet complete 10, DMA error 11.
- R3: A set status bit stays set on every later edge until it is cleared as described in R4, even if its event input is low and even if its capture-enable bit is later dropped.
- R4: A write with `wr_sel` = 0 clears every status bit whose `wr_data` bit is 1. Bits whose `wr_data` bit is 0 keep their value.
- R5: When a new enabled event and a clear of the same status bit fall on the same edge, the bit ends up set.
- R6: `irq` is high exactly when, for at least one bit position, the status, capture-enable and request-gate bits are all 1.
- R7: `wr_sel`/`rd_sel` encoding: 0 = status, 1 = capture-enable, 2 = request-gate, 3 = none. Writes with selector 1 or 2 load that register. A write with selector 3 changes nothing, and a read with selector 3 returns 0. Bits 6, 7 and 8 always read 0 in all three registers.
- R8: A `soft_rst_evt` pulse acts as an event on both TX empty (bit 0) and RX empty (bit 3), each gated by its own capture-enable bit.
- R9: After 0 is written to both capture-enable and request-gate, `irq` is low and stays low. The status bits already held keep their values.
- R10: A read of status with no bit set returns 0, so software can recognise a spurious request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_tx_empty | input | 1 | TX FIFO empty pulse |
| ev_tx_full | input | 1 | TX FIFO full pulse |
| ev_tx_thr | input | 1 | TX FIFO threshold pulse |
| ev_rx_empty | input | 1 | RX FIFO empty pulse |
| ev_rx_full | input | 1 | RX FIFO full pulse |
| ev_rx_thr | input | 1 | RX FIFO threshold pulse |
| ev_desc_done | input | 1 | Descriptor finished pulse |
| ev_pkt_done | input | 1 | Packet finished pulse |
| ev_dma_err | input | 1 | DMA error pulse |
| soft_rst_evt | input | 1 | Soft-reset pulse from the engine |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target selector |
| wr_data | input | 12 | Write data |
| rd_sel | input | 2 | Read source selector |
| rd_data | output | 12 | Read data (combinational) |
| irq | output | 1 | Level interrupt request |

## Verification
A new enabled event and a write-one-to-clear of the same status bit can fall on the same clock edge. The bench sets this up on purpose. It pulses packet complete while clearing bit 10, and does the same through the soft-reset pulse while clearing bits 0 and 3. It then reads status back and expects the bits to be set. The random phase also produces many of these collisions, because clear writes carry random masks while random events keep arriving. Every read is judged against a bench model in which the set term has priority over the clear term.

// File: rtl/isu_pkg.sv
package isu_pkg;

    localparam int REG_W = 12;

    // event bit positions (decoded by software)
    localparam int B_TX_EMPTY  = 0;
    localparam int B_TX_FULL   = 1;
    localparam int B_TX_THR    = 2;
    localparam int B_RX_EMPTY  = 3;
    localparam int B_RX_FULL   = 4;
    localparam int B_RX_THR    = 5;
    localparam int B_DESC_DONE = 9;
    localparam int B_PKT_DONE  = 10;
    localparam int B_DMA_ERR   = 11;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_GATE   = 2'd2,
        SEL_NONE   = 2'd3
    } sel_e;

    typedef struct packed {
        logic tx_empty;
        logic tx_full;
        logic tx_thr;
        logic rx_empty;
        logic rx_full;
        logic rx_thr;
        logic desc_done;
        logic pkt_done;
        logic dma_err;
        logic soft_rst;
    } evt_s;

    function automatic logic [REG_W-1:0] impl_mask();
        logic [REG_W-1:0] m;
        m = '0;
        m[B_TX_EMPTY]  = 1'b1;
        m[B_TX_FULL]   = 1'b1;
        m[B_TX_THR]    = 1'b1;
        m[B_RX_EMPTY]  = 1'b1;
        m[B_RX_FULL]   = 1'b1;
        m[B_RX_THR]    = 1'b1;
        m[B_DESC_DONE] = 1'b1;
        m[B_PKT_DONE]  = 1'b1;
        m[B_DMA_ERR]   = 1'b1;
        return m;
    endfunction

    localparam logic [REG_W-1:0] IMPL_MASK = impl_mask();

endpackage

// File: rtl/isu_event_map.sv
module isu_event_map
    import isu_pkg::*;
#(
    parameter int W = REG_W
) (
    input  evt_s         evt,
    output logic [W-1:0] ev_vec
);
    always_comb begin
        ev_vec = '0;
        ev_vec[B_TX_EMPTY]  = evt.tx_empty | evt.soft_rst;
        ev_vec[B_TX_FULL]   = evt.tx_full;
        ev_vec[B_TX_THR]    = evt.tx_thr;
        ev_vec[B_RX_EMPTY]  = evt.rx_empty | evt.soft_rst;
        ev_vec[B_RX_FULL]   = evt.rx_full;
        ev_vec[B_RX_THR]    = evt.rx_thr;
        ev_vec[B_DESC_DONE] = evt.desc_done;
        ev_vec[B_PKT_DONE]  = evt.pkt_done;
        ev_vec[B_DMA_ERR]   = evt.dma_err;
    end
endmodule

// File: rtl/isu_mask_reg.sv
module isu_mask_reg
    import isu_pkg::*;
#(
    parameter int            W    = REG_W,
    parameter logic [W-1:0]  MASK = IMPL_MASK,
    parameter logic [1:0]    SEL  = 2'd1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wr_en && wr_sel == SEL)
            q <= wr_data & MASK;
    end
endmodule

// File: rtl/isu_status_bank.sv
module isu_status_bank
    import isu_pkg::*;
#(
    parameter int           W    = REG_W,
    parameter logic [W-1:0] MASK = IMPL_MASK
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] ev_vec,
    input  logic [W-1:0] cap_en,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] stat
);
    logic [W-1:0] set_v;
    logic [W-1:0] clr_v;

    assign set_v = ev_vec & cap_en & MASK;
    assign clr_v = clr_vec & MASK;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic b_q;
        always_ff @(posedge clk) begin
            if (rst)
                b_q <= 1'b0;
            else
                b_q <= set_v[i] | (b_q & ~clr_v[i]);
        end
        assign stat[i] = b_q;
    end
endmodule

// File: rtl/isu_irq_gate.sv
module isu_irq_gate #(
    parameter int W = 12
) (
    input  logic [W-1:0] stat,
    input  logic [W-1:0] cap_en,
    input  logic [W-1:0] gate_en,
    output logic         irq
);
    logic [W-1:0] live;

    for (genvar i = 0; i < W; i++) begin : g_term
        assign live[i] = stat[i] & cap_en[i] & gate_en[i];
    end

    assign irq = |live;
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import isu_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ev_tx_empty,
    input  logic         ev_tx_full,
    input  logic         ev_tx_thr,
    input  logic         ev_rx_empty,
    input  logic         ev_rx_full,
    input  logic         ev_rx_thr,
    input  logic         ev_desc_done,
    input  logic         ev_pkt_done,
    input  logic         ev_dma_err,
    input  logic         soft_rst_evt,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   rd_sel,
    output logic [W-1:0] rd_data,
    output logic         irq
);
    localparam logic [W-1:0] MASK = IMPL_MASK[W-1:0];

    evt_s         evt;
    logic [W-1:0] ev_vec;
    logic [W-1:0] stat_q;
    logic [W-1:0] en_q;
    logic [W-1:0] sig_q;
    logic [W-1:0] clr_vec;

    always_comb begin
        evt.tx_empty  = ev_tx_empty;
        evt.tx_full   = ev_tx_full;
        evt.tx_thr    = ev_tx_thr;
        evt.rx_empty  = ev_rx_empty;
        evt.rx_full   = ev_rx_full;
        evt.rx_thr    = ev_rx_thr;
        evt.desc_done = ev_desc_done;
        evt.pkt_done  = ev_pkt_done;
        evt.dma_err   = ev_dma_err;
        evt.soft_rst  = soft_rst_evt;
    end

    isu_event_map #(.W(W)) u_map (
        .evt    (evt),
        .ev_vec (ev_vec)
    );

    isu_mask_reg #(.W(W), .MASK(MASK), .SEL(SEL_ENABLE)) u_en (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .q       (en_q)
    );

    isu_mask_reg #(.W(W), .MASK(MASK), .SEL(SEL_GATE)) u_sig (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .q       (sig_q)
    );

    assign clr_vec = (wr_en && wr_sel == SEL_STATUS) ? wr_data : '0;

    isu_status_bank #(.W(W), .MASK(MASK)) u_stat (
        .clk     (clk),
        .rst     (rst),
        .ev_vec  (ev_vec),
        .cap_en  (en_q),
        .clr_vec (clr_vec),
        .stat    (stat_q)
    );

    isu_irq_gate #(.W(W)) u_gate (
        .stat    (stat_q),
        .cap_en  (en_q),
        .gate_en (sig_q),
        .irq     (irq)
    );

    always_comb begin
        unique case (sel_e'(rd_sel))
            SEL_STATUS: rd_data = stat_q;
            SEL_ENABLE: rd_data = en_q;
            SEL_GATE:   rd_data = sig_q;
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk
    import isu_pkg::*;
#(
    parameter int W = REG_W
) (
    input logic         clk,
    input logic         rst,
    input logic         wr_en,
    input logic [1:0]   wr_sel,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] ev_vec,
    input logic [W-1:0] stat_q,
    input logic [W-1:0] en_q,
    input logic [W-1:0] sig_q,
    input logic         irq
);
    logic [W-1:0] clr_c;
    assign clr_c = (wr_en && wr_sel == 2'd0) ? wr_data : '0;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (stat_q == '0 && en_q == '0 && sig_q == '0 && !irq));

    p_capture_gate_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(en_q)) == '0));

    p_sticky_hold_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(stat_q) & ~$past(clr_c) & ~stat_q) == '0));

    p_clear_w1c_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & $past(clr_c & ~(ev_vec & en_q))) == '0));

    p_event_wins_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(ev_vec & en_q & IMPL_MASK[W-1:0]) & ~stat_q) == '0));

    p_irq_cause_r6: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((stat_q & en_q & sig_q) != '0));

    p_irq_present_r6: assert property (@(posedge clk) disable iff (rst)
        ((stat_q & en_q & sig_q) != '0) |-> irq);

    p_unimpl_zero_r7: assert property (@(posedge clk) disable iff (rst)
        ((stat_q | en_q | sig_q) & ~IMPL_MASK[W-1:0]) == '0);
endmodule

bind irq_status_unit irq_status_unit_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .ev_vec  (ev_vec),
    .stat_q  (stat_q),
    .en_q    (en_q),
    .sig_q   (sig_q),
    .irq     (irq)
);

// File: tb/irq_status_unit_bench.sv
`timescale 1ns/1ps
module irq_status_unit_bench;
    localparam int          CLK_NS = 20;
    localparam logic [11:0] IMPL   = 12'hE3F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] ev  = '0;
    logic        srst = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd3;
    logic [11:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [11:0] rd_data;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [11:0] m_stat = '0, m_en = '0, m_sig = '0;

    always #(CLK_NS/2) clk = ~clk;

    irq_status_unit u_irq_status_unit (
        .clk(clk), .rst(rst),
        .ev_tx_empty(ev[0]), .ev_tx_full(ev[1]), .ev_tx_thr(ev[2]),
        .ev_rx_empty(ev[3]), .ev_rx_full(ev[4]), .ev_rx_thr(ev[5]),
        .ev_desc_done(ev[9]), .ev_pkt_done(ev[10]), .ev_dma_err(ev[11]),
        .soft_rst_evt(srst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [11:0] f_next_stat(logic [11:0] st, logic [11:0] en,
            logic [11:0] e, logic sr, logic we, logic [1:0] ws, logic [11:0] wd);
        logic [11:0] clr, evv;
        clr = (we && ws == 2'd0) ? wd : 12'h000;
        evv = (e | (sr ? 12'h009 : 12'h000)) & IMPL;
        return ((evv & en) | (st & ~clr)) & IMPL;
    endfunction

    function automatic logic f_irq(logic [11:0] st, logic [11:0] en, logic [11:0] sg);
        return |(st & en & sg);
    endfunction

    task automatic chk(input string tag, input logic [11:0] got, input logic [11:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic read_all(input string tag);
        rd_sel = 2'd0; #1; chk({tag, " status"}, rd_data, m_stat);
        rd_sel = 2'd1; #1; chk({tag, " enable"}, rd_data, m_en);
        rd_sel = 2'd2; #1; chk({tag, " gate"}, rd_data, m_sig);
        rd_sel = 2'd3; #1; chk({tag, " R7 none-read"}, rd_data, 12'h000);
        chk({tag, " R6 irq"}, {11'd0, irq}, {11'd0, f_irq(m_stat, m_en, m_sig)});
    endtask

    task automatic cyc(input logic [11:0] e, input logic sr, input logic we,
                       input logic [1:0] ws, input logic [11:0] wd, input string tag);
        logic [11:0] ns, ne, ng;
        @(negedge clk);
        ev = e; srst = sr; wr_en = we; wr_sel = ws; wr_data = wd;
        ns = f_next_stat(m_stat, m_en, e, sr, we, ws, wd);
        ne = (we && ws == 2'd1) ? (wd & IMPL) : m_en;
        ng = (we && ws == 2'd2) ? (wd & IMPL) : m_sig;
        @(posedge clk); #2;
        m_stat = ns; m_en = ne; m_sig = ng;
        read_all(tag);
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #2;
        read_all("R1 reset");
        @(negedge clk); rst = 1'b0;
        read_all("R1 after release");

        // R2: only bit 9 enabled; events on 9 and 10
        cyc(12'h000, 0, 1, 2'd1, 12'h200, "R2 set enable");
        cyc(12'h600, 0, 0, 2'd3, 12'h000, "R2 capture gated");
        chk("R2 status bit 9 only", m_stat, 12'h200);
        // R3: holds over idle, then enable dropped
        cyc(12'h000, 0, 0, 2'd3, 12'h000, "R3 idle");
        cyc(12'h000, 0, 1, 2'd1, 12'h000, "R3 enable dropped");
        rd_sel = 2'd0; #1; chk("R3 sticky after disable", rd_data, 12'h200);
        // R7: unimplemented bits and selector 3 write
        cyc(12'h000, 0, 1, 2'd1, 12'hFFF, "R7 enable all");
        rd_sel = 2'd1; #1; chk("R7 bits 6-8 zero", rd_data, 12'hE3F);
        cyc(12'h000, 0, 1, 2'd3, 12'h000, "R7 none-write ignored");
        // R6: gate blocks then passes
        cyc(12'h001, 0, 0, 2'd3, 12'h000, "R6 event, gate closed");
        chk("R6 irq low gate closed", {11'd0, irq}, 12'h000);
        cyc(12'h000, 0, 1, 2'd2, 12'h001, "R6 gate open");
        chk("R6 irq high", {11'd0, irq}, 12'h001);
        // R4: write-one-to-clear only the selected bit
        cyc(12'h000, 0, 1, 2'd0, 12'h001, "R4 clear bit 0");
        rd_sel = 2'd0; #1; chk("R4 other bit kept", rd_data, 12'h200);
        // R5: event and clear together
        cyc(12'h400, 0, 1, 2'd0, 12'h400, "R5 collision pkt");
        rd_sel = 2'd0; #1; chk("R5 bit 10 set", rd_data & 12'h400, 12'h400);
        // R8: soft reset raises TX and RX empty, colliding with a clear
        cyc(12'h000, 1, 1, 2'd0, 12'h009, "R8 soft reset");
        rd_sel = 2'd0; #1; chk("R8 bits 0 and 3", rd_data & 12'h009, 12'h009);
        // R9: silence everything
        cyc(12'h000, 0, 1, 2'd1, 12'h000, "R9 enable zero");
        cyc(12'h000, 0, 1, 2'd2, 12'h000, "R9 gate zero");
        cyc(12'h800, 1, 0, 2'd3, 12'h000, "R9 events while silenced");
        chk("R9 irq low", {11'd0, irq}, 12'h000);
        rd_sel = 2'd0; #1; chk("R9 status retained", rd_data, 12'h609);
        // R10: clear all, read zero
        cyc(12'h000, 0, 1, 2'd0, 12'hFFF, "R10 clear all");
        rd_sel = 2'd0; #1; chk("R10 empty status", rd_data, 12'h000);

        // constrained random mix
        for (int i = 0; i < 600; i++) begin
            logic [11:0] e, wd;
            logic sr, we;
            logic [1:0] ws;
            e  = 12'($urandom) & 12'($urandom) & 12'($urandom);
            sr = ($urandom % 16) == 0;
            we = ($urandom % 3) == 0;
            ws = 2'($urandom);
            wd = 12'($urandom);
            cyc(e, sr, we, ws, wd, "R2-R7 random");
        end

        // reset in the middle
        @(negedge clk); rst = 1'b1; ev = '0; srst = 1'b0; wr_en = 1'b0;
        @(posedge clk); #2;
        m_stat = '0; m_en = '0; m_sig = '0;
        read_all("R1 mid reset");
        @(negedge clk); rst = 1'b0;

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule